// File: doc/BRIEF.md
# Decoupled Load Register Scoreboard

This block lets an in-order, multithreaded pipeline keep running while loads are outstanding. It tracks one valid bit for each register of each hardware context. When a load leaves the execute-stage holding register, its destination register is marked not-valid and the thread carries on. A later instruction that reads a not-valid register, or that needs a peripheral operand that has not arrived, waits in its own context's holding register. Other contexts keep running.

Loads that wait for memory are queued in order in a per-context access queue. Memory replies are queued in order in a per-context data queue. The head entries of the two queues are paired to produce a register write-back. When the data is already there as the load leaves, the write-back happens in that same cycle, and the register stays valid. The memory arbiter and the ALU datapath are outside this block. The block issues each instruction to execute, or to the load path, and it reports load write-backs.

Top module: `dsb_scoreboard`

## Requirements
- R1: After a synchronous active-low reset:
  - every register valid bit is 1;
  - every holding register is empty, so `iss_ready` is all ones;
  - `ex_valid` and `wb_valid` are 0.
- R2: When a load leaves its holding register (`ex_valid` with `ex_load`=1) and no write-back to the same context and register happens in that cycle, that register's valid bit reads 0 from the next cycle on.
- R3: A held instruction leaves only if all of these hold:
  - both source registers are valid;
  - its peripheral operand is available, when it needs one (`periph_ok` bit of its context);
  - the conditions of R5 and R6 are met.
  Until it leaves, it stays unchanged in its context's holding register.
- R4: When a write-back and a load invalidation target the same context and register in the same cycle, the write-back wins and the valid bit stays 1.
- R5: An instruction does not leave while its destination register is not valid.
- R6: A load does not leave while its context's access queue holds `ACC_DEPTH` entries.
- R7: Per context, load destinations and memory replies are paired strictly in order. A write-back reports `wb_reg` from the oldest waiting load and `wb_data` from the oldest reply; a load leaving now or a reply arriving now serves when its queue is empty.
- R8: At most one write-back happens per cycle. Among the contexts that can pair, the lowest-numbered one is granted and the others keep their entries.
- R9: A non-load instruction that leaves changes no valid bit and produces no write-back.
- R10: `iss_ready[c]` is 1 when context c's holding register is empty or is emptying in this cycle. An issue to a context whose `iss_ready` bit is 0 is ignored.
- R11: At most one held instruction leaves per cycle; the lowest-numbered eligible context goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_ctx | input | CTX_W | Context of the offered instruction |
| iss_load | input | 1 | 1 = load, 0 = execution instruction |
| iss_periph | input | 1 | Instruction needs a peripheral operand |
| iss_src_a | input | REG_W | First source register |
| iss_src_b | input | REG_W | Second source register |
| iss_dst | input | REG_W | Destination register |
| iss_ready | output | NCTX | Per-context issue acceptance |
| periph_ok | input | NCTX | Per-context peripheral operand available |
| rsp_valid | input | 1 | Memory reply present |
| rsp_ctx | input | CTX_W | Context of the memory reply |
| rsp_data | input | DATA_W | Memory reply data |
| ex_valid | output | 1 | A held instruction leaves this cycle |
| ex_ctx | output | CTX_W | Its context |
| ex_load | output | 1 | It is a load |
| ex_dst | output | REG_W | Its destination register |
| wb_valid | output | 1 | Load write-back this cycle |
| wb_ctx | output | CTX_W | Write-back context |
| wb_reg | output | REG_W | Write-back register |
| wb_data | output | DATA_W | Write-back data |
| reg_valid | output | NCTX*NREG | Valid bits; bit c*NREG+r is register r of context c |

## Verification
The assertions check these on every cycle:
- the queues never overflow;
- a context never holds more replies than waiting loads;
- a held instruction stays unchanged until it leaves;
- a load invalidation takes effect;
- a simultaneous write-back keeps the bit set.

Only the bench's scenarios can show the rest:
- the lowest-context priority of issue-out and write-back;
- in-order pairing of destinations with data;
- back-pressure when an access queue fills during a long stretch without replies;
- issues ignored while the target context is busy.

// File: rtl/dsb_pkg.sv
// Shared sizes and types for the decoupled load scoreboard.
// Assumes NCTX and NREG are powers of two.
package dsb_pkg;
    localparam int NCTX      = 4;
    localparam int NREG      = 8;
    localparam int ACC_DEPTH = 4;
    localparam int DATA_W    = 16;
    localparam int CTX_W     = $clog2(NCTX);
    localparam int REG_W     = $clog2(NREG);
    localparam int CNT_W     = $clog2(ACC_DEPTH + 1);

    typedef struct packed {
        logic             load;
        logic             periph;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic [REG_W-1:0] dst;
    } instr_t;
endpackage

// File: rtl/dsb_fifo.sv
// In-order queue with a count output, used for both access and data queues.
// Assumes the caller never pushes when full (unless also popping) and never
// pops when empty; DEPTH >= 2.
module dsb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write storage on push.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= din;
    end

    // Advance pointers and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign dout = store[rd_ptr];

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && !pop && count == CNT_W'(DEPTH)));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && count == '0));
endmodule

// File: rtl/dsb_hold_slot.sv
// Per-context execute-stage holding register. Captures an accepted
// instruction and keeps it until the scoreboard lets it leave.
// Assumes load_en is only raised when the slot is empty or leaving.
module dsb_hold_slot
    import dsb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_en,
    input  instr_t load_instr,
    input  logic   leave,
    output logic   full,
    output instr_t instr
);
    // Track occupancy and capture new instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full  <= 1'b0;
            instr <= '0;
        end else begin
            if (load_en) begin
                full  <= 1'b1;
                instr <= load_instr;
            end else if (leave) begin
                full <= 1'b0;
            end
        end
    end

    assert_leave_needs_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        leave |-> full);
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !leave) |=> (full && $stable(instr)));
endmodule

// File: rtl/dsb_valid_array.sv
// Valid bit per register per context. A load invalidation clears a bit and a
// write-back sets one; when both hit the same bit, the set wins.
module dsb_valid_array
    import dsb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_en,
    input  logic [CTX_W-1:0]     clr_ctx,
    input  logic [REG_W-1:0]     clr_reg,
    input  logic                 set_en,
    input  logic [CTX_W-1:0]     set_ctx,
    input  logic [REG_W-1:0]     set_reg,
    output logic [NCTX*NREG-1:0] vbits
);
    localparam int IDX_W = CTX_W + REG_W;
    logic [IDX_W-1:0] clr_idx, set_idx;

    assign clr_idx = {clr_ctx, clr_reg};
    assign set_idx = {set_ctx, set_reg};

    // Update valid bits, giving returning data priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbits <= '1;
        end else begin
            for (int i = 0; i < NCTX * NREG; i++) begin
                if (set_en && set_idx == IDX_W'(i))      vbits[i] <= 1'b1;
                else if (clr_en && clr_idx == IDX_W'(i)) vbits[i] <= 1'b0;
            end
        end
    end

    assert_data_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> vbits[$past(set_idx)]);
    assert_load_invalidates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !vbits[$past(clr_idx)]);
endmodule

// File: rtl/dsb_scoreboard.sv
// Decoupled load scoreboard top. Holds one instruction per context until
// its operands and destination are valid, lets at most one leave per cycle,
// queues outstanding loads and memory replies per context, and pairs them
// in order into a single write-back port.
// Assumes memory replies for a context arrive in load order and never
// before the matching load has left.
module dsb_scoreboard
    import dsb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic [CTX_W-1:0]     iss_ctx,
    input  logic                 iss_load,
    input  logic                 iss_periph,
    input  logic [REG_W-1:0]     iss_src_a,
    input  logic [REG_W-1:0]     iss_src_b,
    input  logic [REG_W-1:0]     iss_dst,
    output logic [NCTX-1:0]      iss_ready,
    input  logic [NCTX-1:0]      periph_ok,
    input  logic                 rsp_valid,
    input  logic [CTX_W-1:0]     rsp_ctx,
    input  logic [DATA_W-1:0]    rsp_data,
    output logic                 ex_valid,
    output logic [CTX_W-1:0]     ex_ctx,
    output logic                 ex_load,
    output logic [REG_W-1:0]     ex_dst,
    output logic                 wb_valid,
    output logic [CTX_W-1:0]     wb_ctx,
    output logic [REG_W-1:0]     wb_reg,
    output logic [DATA_W-1:0]    wb_data,
    output logic [NCTX*NREG-1:0] reg_valid
);
    instr_t              iss_instr;
    instr_t              slot_q   [NCTX];
    logic [NCTX-1:0]     slot_full, slot_ok, slot_fire, slot_take;
    logic [NCTX-1:0]     rsp_hit, pair_ok, grant;
    logic [NCTX-1:0]     acc_push, acc_pop, mem_push, mem_pop;
    logic [CNT_W-1:0]    acc_cnt  [NCTX];
    logic [CNT_W-1:0]    mem_cnt  [NCTX];
    logic [REG_W-1:0]    acc_head [NCTX];
    logic [DATA_W-1:0]   mem_head [NCTX];

    assign iss_instr = '{load: iss_load, periph: iss_periph,
                         src_a: iss_src_a, src_b: iss_src_b, dst: iss_dst};

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        logic [NREG-1:0] rv;
        assign rv = reg_valid[c*NREG +: NREG];

        assign iss_ready[c] = !slot_full[c] || slot_fire[c];
        assign slot_take[c] = iss_valid && (iss_ctx == CTX_W'(c)) && iss_ready[c];
        assign rsp_hit[c]   = rsp_valid && (rsp_ctx == CTX_W'(c));

        // Eligibility: operands and destination valid, peripheral ready, room.
        assign slot_ok[c] = slot_full[c]
                          && rv[slot_q[c].src_a] && rv[slot_q[c].src_b]
                          && rv[slot_q[c].dst]
                          && (!slot_q[c].periph || periph_ok[c])
                          && (!slot_q[c].load || acc_cnt[c] != CNT_W'(ACC_DEPTH));

        // Pairing possible when a load and its data both exist now.
        assign pair_ok[c] = ((acc_cnt[c] != '0) || (slot_fire[c] && slot_q[c].load))
                         && ((mem_cnt[c] != '0) || rsp_hit[c]);

        assign acc_push[c] = slot_fire[c] && slot_q[c].load && !(grant[c] && acc_cnt[c] == '0);
        assign acc_pop[c]  = grant[c] && (acc_cnt[c] != '0);
        assign mem_push[c] = rsp_hit[c] && !(grant[c] && mem_cnt[c] == '0);
        assign mem_pop[c]  = grant[c] && (mem_cnt[c] != '0);

        dsb_hold_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_en    (slot_take[c]),
            .load_instr (iss_instr),
            .leave      (slot_fire[c]),
            .full       (slot_full[c]),
            .instr      (slot_q[c])
        );

        dsb_fifo #(.W(REG_W), .DEPTH(ACC_DEPTH)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (acc_push[c]),
            .pop   (acc_pop[c]),
            .din   (slot_q[c].dst),
            .dout  (acc_head[c]),
            .count (acc_cnt[c])
        );

        dsb_fifo #(.W(DATA_W), .DEPTH(ACC_DEPTH)) u_mem (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (mem_push[c]),
            .pop   (mem_pop[c]),
            .din   (rsp_data),
            .dout  (mem_head[c]),
            .count (mem_cnt[c])
        );

        assert_replies_le_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
            mem_cnt[c] <= acc_cnt[c]);
    end

    // Pick the lowest eligible context to leave the holding stage.
    always_comb begin
        slot_fire = '0;
        for (int c = NCTX - 1; c >= 0; c--) begin
            if (slot_ok[c]) begin
                slot_fire    = '0;
                slot_fire[c] = 1'b1;
            end
        end
    end

    // Grant the single write-back port to the lowest pairable context.
    always_comb begin
        grant = '0;
        for (int c = NCTX - 1; c >= 0; c--) begin
            if (pair_ok[c]) begin
                grant    = '0;
                grant[c] = 1'b1;
            end
        end
    end

    // Drive the execute-side outputs from the leaving slot.
    always_comb begin
        ex_ctx = '0;
        for (int c = 0; c < NCTX; c++) begin
            if (slot_fire[c]) ex_ctx = CTX_W'(c);
        end
        ex_valid = |slot_fire;
        ex_load  = ex_valid && slot_q[ex_ctx].load;
        ex_dst   = slot_q[ex_ctx].dst;
    end

    // Drive the write-back outputs from queue heads or same-cycle bypass.
    always_comb begin
        wb_ctx = '0;
        for (int c = 0; c < NCTX; c++) begin
            if (grant[c]) wb_ctx = CTX_W'(c);
        end
        wb_valid = |grant;
        wb_reg   = (acc_cnt[wb_ctx] != '0) ? acc_head[wb_ctx] : slot_q[wb_ctx].dst;
        wb_data  = (mem_cnt[wb_ctx] != '0) ? mem_head[wb_ctx] : rsp_data;
    end

    dsb_valid_array u_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (ex_valid && ex_load),
        .clr_ctx (ex_ctx),
        .clr_reg (ex_dst),
        .set_en  (wb_valid),
        .set_ctx (wb_ctx),
        .set_reg (wb_reg),
        .vbits   (reg_valid)
    );

    assert_exec_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_load && !wb_valid) |=> (reg_valid == $past(reg_valid)));
endmodule

// File: tb/test_dsb_scoreboard.sv
`timescale 1ns/1ps
module test_dsb_scoreboard;
    import dsb_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 iss_valid = 1'b0;
    logic [CTX_W-1:0]     iss_ctx = '0;
    logic                 iss_load = 1'b0, iss_periph = 1'b0;
    logic [REG_W-1:0]     iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic [NCTX-1:0]      iss_ready;
    logic [NCTX-1:0]      periph_ok = '0;
    logic                 rsp_valid = 1'b0;
    logic [CTX_W-1:0]     rsp_ctx = '0;
    logic [DATA_W-1:0]    rsp_data = '0;
    logic                 ex_valid, ex_load, wb_valid;
    logic [CTX_W-1:0]     ex_ctx, wb_ctx;
    logic [REG_W-1:0]     ex_dst, wb_reg;
    logic [DATA_W-1:0]    wb_data;
    logic [NCTX*NREG-1:0] reg_valid;

    always #4 clk = ~clk;

    dsb_scoreboard i_dsb_scoreboard (.*);

    int tests = 0, fails = 0;
    bit done = 0;

    // Behavioural model state
    bit mvalid [NCTX][NREG];
    bit mfull  [NCTX];
    bit mload  [NCTX], mper [NCTX];
    int ma [NCTX], mb [NCTX], md [NCTX];
    int accq [NCTX][$];
    int memq [NCTX][$];
    int outst [NCTX];

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCTX; c++) begin
            mfull[c] = 0; outst[c] = 0;
            for (int r = 0; r < NREG; r++) mvalid[c][r] = 1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", "iss_ready", 64'(iss_ready), 64'({NCTX{1'b1}}));
        check("R1", "reg_valid", 64'(reg_valid), 64'({NCTX*NREG{1'b1}}));
        check("R1", "ex_valid", 64'(ex_valid), 64'd0);
        check("R1", "wb_valid", 64'(wb_valid), 64'd0);

        for (int cyc = 0; cyc < 4000; cyc++) begin
            int fire, rc, grant, rsp_pct, exp_reg, exp_data;
            bit [NCTX-1:0] rdy;
            logic [NCTX*NREG-1:0] expv;
            bit paired_now;
            @(negedge clk);
            // phases: mixed, reply drought (fills queues), reply flood
            if (cyc < 1300)      rsp_pct = 50;
            else if (cyc < 2300) rsp_pct = 4;
            else                 rsp_pct = 90;

            for (int c = 0; c < NCTX; c++) periph_ok[c] = ($urandom_range(99) < 80);

            fire = -1;
            for (int c = NCTX - 1; c >= 0; c--) begin
                if (mfull[c] && mvalid[c][ma[c]] && mvalid[c][mb[c]] && mvalid[c][md[c]]
                    && (!mper[c] || periph_ok[c])
                    && (!mload[c] || accq[c].size() < ACC_DEPTH))
                    fire = c;
            end

            rc = -1;
            if ($urandom_range(99) < rsp_pct) begin
                int start = $urandom_range(NCTX - 1);
                for (int k = 0; k < NCTX; k++) begin
                    int c = (start + k) % NCTX;
                    int pend = outst[c] + ((fire == c && mload[c]) ? 1 : 0);
                    if (rc < 0 && pend > 0) rc = c;
                end
            end
            rsp_valid = (rc >= 0);
            rsp_ctx   = (rc >= 0) ? CTX_W'(rc) : '0;
            rsp_data  = DATA_W'($urandom);

            iss_valid  = ($urandom_range(99) < 70);
            iss_ctx    = CTX_W'($urandom_range(NCTX - 1));
            iss_load   = $urandom_range(1);
            iss_periph = ($urandom_range(99) < 20);
            iss_src_a  = REG_W'($urandom_range(NREG - 1));
            iss_src_b  = REG_W'($urandom_range(NREG - 1));
            iss_dst    = REG_W'($urandom_range(NREG - 1));
            #1;

            for (int c = 0; c < NCTX; c++) rdy[c] = !mfull[c] || (fire == c);
            grant = -1;
            for (int c = NCTX - 1; c >= 0; c--) begin
                int na = accq[c].size() + ((fire == c && mload[c]) ? 1 : 0);
                int nd = memq[c].size() + ((rc == c) ? 1 : 0);
                if (na > 0 && nd > 0) grant = c;
            end
            exp_reg = 0; exp_data = 0;
            if (grant >= 0) begin
                exp_reg  = (accq[grant].size() > 0) ? accq[grant][0] : md[grant];
                exp_data = (memq[grant].size() > 0) ? memq[grant][0] : int'(rsp_data);
            end
            for (int c = 0; c < NCTX; c++)
                for (int r = 0; r < NREG; r++) expv[c*NREG + r] = mvalid[c][r];

            check("R10", "iss_ready", 64'(iss_ready), 64'(rdy));
            check("R2 R4 R9", "reg_valid", 64'(reg_valid), 64'(expv));
            check("R3 R5 R6 R11", "ex_valid", 64'(ex_valid), 64'(fire >= 0));
            if (fire >= 0) begin
                check("R11", "ex_ctx", 64'(ex_ctx), 64'(fire));
                check("R3", "ex_load", 64'(ex_load), 64'(mload[fire]));
                check("R3", "ex_dst", 64'(ex_dst), 64'(md[fire]));
            end
            check("R7 R8", "wb_valid", 64'(wb_valid), 64'(grant >= 0));
            if (grant >= 0) begin
                check("R8", "wb_ctx", 64'(wb_ctx), 64'(grant));
                check("R7", "wb_reg", 64'(wb_reg), 64'(exp_reg));
                check("R7", "wb_data", 64'(wb_data), 64'(exp_data));
            end

            // model update for the coming edge
            if (fire >= 0) begin
                mfull[fire] = 0;
                if (mload[fire]) begin
                    accq[fire].push_back(md[fire]);
                    outst[fire]++;
                    mvalid[fire][md[fire]] = 0;
                end
            end
            if (rc >= 0) begin
                memq[rc].push_back(int'(rsp_data));
                outst[rc]--;
            end
            paired_now = (grant >= 0);
            if (paired_now) begin
                int r = accq[grant].pop_front();
                void'(memq[grant].pop_front());
                mvalid[grant][r] = 1;
            end
            if (iss_valid && rdy[iss_ctx]) begin
                mfull[iss_ctx] = 1;
                mload[iss_ctx] = iss_load;
                mper[iss_ctx]  = iss_periph;
                ma[iss_ctx]    = int'(iss_src_a);
                mb[iss_ctx]    = int'(iss_src_b);
                md[iss_ctx]    = int'(iss_dst);
            end
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule